// File: doc/BRIEF.md
# Dual-Mode FIFO Read-Side Status Controller

This block controls the read side of a dual-clock FIFO. It runs on the read clock and takes the write pointer after it has been brought across into this clock domain. It subtracts its own read pointer from that pointer to find how many words are held in memory. From that count it drives three things: a status flag, a strobe that advances the read pointer, and a strobe that loads the FIFO output register. The memory array, the write side and the pointer synchronizer sit outside this block.

There are two modes. In fall-through mode the flag means "output valid". The first word that reaches an empty memory moves into the output register without any read request. This happens on the third rising read-clock edge after the word becomes visible, and the flag rises on that same edge. Once a word sits in the output register it no longer counts as held in memory. In standard mode the flag means "not empty". It rises on the second rising edge after the word becomes visible, and a word moves into the output register only on a read request made while the flag is high. In both modes the arrival delay starts again each time the memory count returns to zero. The mode is a configuration input and is changed only while reset is asserted.

Top module: `rd_status_ctrl`

## Requirements
- R1: While reset is asserted, and on the edges just after it is released with no word written, the flag is low and neither strobe pulses.
- R2: In fall-through mode (`fwft_mode` = 1), take a word that becomes visible on `wptr_sync` between edges E0 and E1 while the memory is empty. `oreg_load` pulses for edge E3 and not for E1 or E2. The flag goes high on E3.
- R3: In fall-through mode, while the flag is high and `rd_en` is low, no load occurs and the flag stays high.
- R4: In fall-through mode, `rd_en` with the flag high consumes the output word. If a settled word is held in memory, it loads on that edge and the flag stays high. If no word is held, the flag falls and nothing loads.
- R5: In standard mode (`fwft_mode` = 0), a word that becomes visible between E0 and E1 raises the flag on E2. No load happens without a read request.
- R6: In standard mode, `rd_en` while the flag is low is ignored. There is no load and no pointer increment.
- R7: In standard mode, `rd_en` with the flag high loads a word on that edge. If that was the last word in memory, the flag falls on the same edge. Otherwise the flag stays high.
- R8: `rptr_inc` pulses on exactly the edges on which `oreg_load` pulses. The read pointer wraps correctly past the depth of the address range.
- R9: After the memory has drained to zero, the next word that arrives again sees the full latency of its mode.
- R10: In fall-through mode, a word in the output register is not counted as stored. A word written while the output register is full waits the full three edges, even if the output is read in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwft_mode | input | 1 | 1 = fall-through, 0 = standard; static outside reset |
| rd_en | input | 1 | Read request |
| wptr_sync | input | AW+1 | Write pointer already synchronized to the read clock, binary, with wrap bit |
| flag | output | 1 | Output-valid flag (fall-through) or not-empty flag (standard) |
| rptr_inc | output | 1 | Read pointer advances on this edge |
| oreg_load | output | 1 | Output register captures the next word on this edge |

## Verification
A fault in the internal age counter shows up as the flag rising one edge early or late after a word arrives into an empty memory. That error is visible on the very first word, so each test checks the exact edge rather than an eventual rise. A read pointer that drifts would leave the flag high over a drained memory, or drop it over a non-empty one. This shows within one read after the drift. A flag register that ignores its hold or drop conditions breaks the very next read or idle cycle after the word is loaded.

// File: rtl/rd_status_ctrl.sv
module rd_status_ctrl #(
  parameter int AW         = 4,
  parameter int FWFT_EDGES = 3,
  parameter int STD_EDGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fwft_mode,
  input  logic        rd_en,
  input  logic [AW:0] wptr_sync,
  output logic        flag,
  output logic        rptr_inc,
  output logic        oreg_load
);

  localparam int AGW = $clog2(FWFT_EDGES + 1);
  localparam logic [AGW-1:0] F_THR = AGW'(FWFT_EDGES - 1);
  localparam logic [AGW-1:0] S_THR = AGW'(STD_EDGES - 1);

  logic [AW:0]    rptr, cnt;
  logic [AGW-1:0] age;
  logic           mem_empty, mem_one, nxt_empty, f_ready, flag_d;

  assign cnt       = wptr_sync - rptr;
  assign mem_empty = (cnt == '0);
  assign mem_one   = (cnt == (AW+1)'(1));

  assign f_ready   = !mem_empty && (age >= F_THR);
  assign oreg_load = fwft_mode ? (f_ready && (!flag || rd_en)) : (flag && rd_en);
  assign rptr_inc  = oreg_load;
  assign nxt_empty = mem_empty || (mem_one && oreg_load);

  always_comb begin
    if (fwft_mode)
      flag_d = oreg_load ? 1'b1 : (rd_en ? 1'b0 : flag);
    else
      flag_d = !nxt_empty && (age >= S_THR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr <= '0;
      age  <= '0;
      flag <= 1'b0;
    end else begin
      rptr <= rptr + {{AW{1'b0}}, oreg_load};
      if (nxt_empty)       age <= '0;
      else if (age < F_THR) age <= age + 1'b1;
      flag <= flag_d;
    end
  end

  assert_load_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oreg_load |-> !mem_empty);

  assert_fwft_rise_with_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft_mode && $rose(flag)) |-> $past(oreg_load));

  assert_fwft_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft_mode && flag && !rd_en) |=> flag);

  assert_std_last_read_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft_mode && oreg_load && mem_one) |=> !flag);

  assert_std_rise_needs_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft_mode && $rose(flag)) |-> $past(!mem_empty));

endmodule

// File: tb/rd_status_ctrl_tb.sv
module rd_status_ctrl_tb;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwft_mode = 1'b1;
  logic rd_en = 1'b0;
  logic [AW:0] wptr = '0;
  logic flag, rptr_inc, oreg_load;
  int nvec = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  rd_status_ctrl #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fwft_mode(fwft_mode), .rd_en(rd_en),
    .wptr_sync(wptr), .flag(flag), .rptr_inc(rptr_inc), .oreg_load(oreg_load)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input string req, input logic eld, input logic efl);
    logic ld, inc;
    #1;
    ld = oreg_load;
    inc = rptr_inc;
    @(posedge clk);
    #1;
    chk(req, "load", ld, eld);
    chk("R8", "increment", inc, eld);
    chk(req, "flag", flag, efl);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0;
    fwft_mode = mode;
    rd_en = 1'b0;
    wptr = '0;
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "flag in reset", flag, 1'b0);
    chk("R1", "load in reset", oreg_load, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc("R1", 1'b0, 1'b0);
  endtask

  task automatic t_fwft_latency();
    do_reset(1'b1);
    for (int g = 0; g < 4; g++) begin
      string r;
      r = (g == 0) ? "R2" : "R9";
      wptr = wptr + 1'b1;
      cyc(r, 1'b0, 1'b0);
      cyc(r, 1'b0, 1'b0);
      cyc(r, 1'b1, 1'b1);
      cyc("R3", 1'b0, 1'b1);
      cyc("R3", 1'b0, 1'b1);
      rd_en = 1'b1;
      cyc("R4", 1'b0, 1'b0);
      rd_en = 1'b0;
      for (int k = 0; k < g; k++) cyc("R9", 1'b0, 1'b0);
    end
  endtask

  task automatic t_fwft_stream();
    do_reset(1'b1);
    wptr = wptr + 3'd3;
    cyc("R2", 1'b0, 1'b0);
    cyc("R2", 1'b0, 1'b0);
    cyc("R2", 1'b1, 1'b1);
    cyc("R3", 1'b0, 1'b1);
    rd_en = 1'b1;
    cyc("R4", 1'b1, 1'b1);
    cyc("R4", 1'b1, 1'b1);
    cyc("R4", 1'b0, 1'b0);
    rd_en = 1'b0;
  endtask

  task automatic t_fwft_hidden();
    do_reset(1'b1);
    wptr = wptr + 1'b1;
    cyc("R2", 1'b0, 1'b0);
    cyc("R2", 1'b0, 1'b0);
    cyc("R2", 1'b1, 1'b1);
    wptr = wptr + 1'b1;
    rd_en = 1'b1;
    cyc("R10", 1'b0, 1'b0);
    rd_en = 1'b0;
    cyc("R10", 1'b0, 1'b0);
    cyc("R10", 1'b1, 1'b1);
  endtask

  task automatic t_std_single();
    do_reset(1'b0);
    rd_en = 1'b1;
    wptr = wptr + 1'b1;
    cyc("R6", 1'b0, 1'b0);
    cyc("R5", 1'b0, 1'b1);
    cyc("R7", 1'b1, 1'b0);
    rd_en = 1'b0;
    wptr = wptr + 1'b1;
    cyc("R9", 1'b0, 1'b0);
    cyc("R9", 1'b0, 1'b1);
    cyc("R5", 1'b0, 1'b1);
    rd_en = 1'b1;
    cyc("R7", 1'b1, 1'b0);
    rd_en = 1'b0;
  endtask

  task automatic t_std_burst();
    do_reset(1'b0);
    wptr = wptr + 2'd2;
    cyc("R5", 1'b0, 1'b0);
    cyc("R5", 1'b0, 1'b1);
    rd_en = 1'b1;
    cyc("R7", 1'b1, 1'b1);
    cyc("R7", 1'b1, 1'b0);
    cyc("R6", 1'b0, 1'b0);
    rd_en = 1'b0;
  endtask

  task automatic t_wrap();
    do_reset(1'b1);
    rd_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      wptr = wptr + 3'd3;
      cyc("R8", 1'b0, 1'b0);
      cyc("R8", 1'b0, 1'b0);
      cyc("R8", 1'b1, 1'b1);
      cyc("R8", 1'b1, 1'b1);
      cyc("R8", 1'b1, 1'b1);
      cyc("R8", 1'b0, 1'b0);
    end
    rd_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_fwft_latency();
    t_fwft_stream();
    t_fwft_hidden();
    t_std_single();
    t_std_burst();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule